// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a chip. A sixteen-state controller advances on the rising edge of the test clock, steered by the mode-select input. It keeps an eight-bit instruction register. Each opcode picks one data register to sit between the serial input and the serial output:

- a single-bit bypass stage,
- a 32-bit identification register,
- a boundary chain of input and output cells. Each cell has a capture stage and an update latch.

Two controls go out to the pad ring. One puts every functional output into high impedance. The other makes the pads take their values from the boundary update latches instead of from the core.

After reset, or whenever the controller passes through Test-Logic-Reset, the active instruction is the identification opcode. A board tester can therefore read the device identity without first loading an instruction. The serial output is registered on the falling edge of the test clock. It is enabled only while one of the two shift states is active.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the standard sixteen-state transition map, with tms sampled on the rising edge of tck. Five consecutive rising edges with tms=1 reach Test-Logic-Reset from any state.
- R2: While trst_n is low, and on every falling edge spent in Test-Logic-Reset, the active instruction becomes 8'h02. This selects the identification register as the data path.
- R3: Capture-IR loads 8'h01 into the instruction shift stage. That value leaves on tdo least-significant bit first during Shift-IR.
- R4: The active instruction changes only on the falling edge of tck in Update-IR. Shifting a new opcode leaves the pad controls untouched until then.
- R5: The opcodes decode as follows: 8'hFF bypass, 8'h00 external test, 8'h01 sample/preload, 8'h02 identification, 8'h04 clamp, 8'h08 high impedance. Any other code behaves as bypass.
- R6: The bypass stage captures 0 in Capture-DR and delays tdi by one shift.
- R7: The identification register captures ID_CODE with bit 0 forced to 1. It shifts out least-significant bit first.
- R8: In the boundary chain, bits [NUM_IN-1:0] capture pin_in and bits [NUM_IN+NUM_OUT-1:NUM_IN] capture core_out. tdi enters at the most significant bit and the least significant bit drives tdo.
- R9: The boundary update latches load on the falling edge of tck in Update-DR, and only under external test or sample/preload. Under sample/preload, pin_out keeps following core_out.
- R10: Under external test and clamp, bsr_drive is 1 and pin_out equals the output-cell update latches. Clamp shifts through the bypass stage. Under every other instruction, bsr_drive is 0 and pin_out equals core_out.
- R11: pad_hiz is 1 only under the high-impedance instruction, which shifts through the bypass stage.
- R12: tdo changes only on the falling edge of tck. tdo_oe is 1 only while Shift-IR or Shift-DR is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data input |
| pin_in | input | NUM_IN | Values seen at the input pads |
| core_out | input | NUM_OUT | Functional output values from the core |
| tdo | output | 1 | Serial data output, falling-edge registered |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_out | output | NUM_OUT | Values driven toward the output pads |
| pad_hiz | output | 1 | Tri-state request for all functional outputs |
| bsr_drive | output | 1 | Pads take values from the boundary update latches |

## Verification
The bench builds the port with NUM_IN=3, NUM_OUT=4 and ID_CODE=32'h5A5A1234. Bit 0 of that ID is 0, so the forced 1 in the captured identity can be told apart from the parameter. The seven-cell chain is short enough that a 40-bit data scan shows the captured cells first and then the delayed input stream. From that one stream, the bench can tell bypass, identification and boundary paths apart for every opcode, the undefined ones included. With four output cells, a preloaded pattern can be followed on pin_out through sample/preload, external test and clamp.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
  localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h01;
  localparam logic [IR_W-1:0] OP_IDCODE  = 8'h02;
  localparam logic [IR_W-1:0] OP_CLAMP   = 8'h04;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h08;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     drive;    // pads take update latches
    logic     hiz;      // tri-state request
    logic     bsr_upd;  // update latches may load
  } ir_dec_t;

  function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{path: PATH_BYP, drive: 1'b0, hiz: 1'b0, bsr_upd: 1'b0};
    case (op)
      OP_EXTEST: begin d.path = PATH_BSR; d.drive = 1'b1; d.bsr_upd = 1'b1; end
      OP_SAMPLE: begin d.path = PATH_BSR; d.bsr_upd = 1'b1; end
      OP_IDCODE: d.path = PATH_ID;
      OP_CLAMP:  d.drive = 1'b1;
      OP_HIGHZ:  d.hiz = 1'b1;
      default:   d.path = PATH_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  localparam int RUN_LEN = 5;
  localparam int CNT_W   = $clog2(RUN_LEN + 1);

  tap_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_RESET:  state_nx = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_nx = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_nx = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nx;
  end

  // run length of consecutive tms=1 samples, for the reset-path check
  logic [CNT_W-1:0] ones_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                         ones_run <= '0;
    else if (!tms)                      ones_run <= '0;
    else if (ones_run != CNT_W'(RUN_LEN)) ones_run <= ones_run + 1'b1;
  end

  assert_five_ones_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_run == CNT_W'(RUN_LEN)) |-> (state == ST_RESET));

  assert_reset_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output ir_dec_t    dec
);

  logic [IR_W-1:0] ir_sr, ir_sr_nx;
  logic            ir_sr_en;
  logic [IR_W-1:0] ir_act, ir_act_nx;
  logic            ir_act_en;

  // shift stage, rising edge
  always_comb begin
    ir_sr_en = 1'b0;
    ir_sr_nx = ir_sr;
    if (state == ST_CAP_IR) begin
      ir_sr_en = 1'b1;
      ir_sr_nx = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sr_en = 1'b1;
      ir_sr_nx = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        ir_sr <= IR_CAPTURE;
    else if (ir_sr_en) ir_sr <= ir_sr_nx;
  end

  // active instruction latch, falling edge
  always_comb begin
    ir_act_en = (state == ST_RESET) || (state == ST_UPD_IR);
    ir_act_nx = (state == ST_RESET) ? OP_IDCODE : ir_sr;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)         ir_act <= OP_IDCODE;
    else if (ir_act_en) ir_act <= ir_act_nx;
  end

  assign ir_lsb = ir_sr[0];
  assign dec    = decode_op(ir_act);

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  assert_ir_stable_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_RESET) |-> $stable(ir_act));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          NUM_IN  = 8,
  parameter int          NUM_OUT = 8,
  parameter logic [31:0] ID_CODE = 32'h1000_0FFF
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  input  ir_dec_t            dec,
  input  logic [NUM_IN-1:0]  pin_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic               dr_lsb,
  output logic [NUM_OUT-1:0] pin_out
);

  localparam int BSR_LEN = NUM_IN + NUM_OUT;
  localparam int ID_W    = 32;

  logic cap, shf;
  assign cap = (state == ST_CAP_DR);
  assign shf = (state == ST_SH_DR);

  // capture vector, one source per cell
  logic [BSR_LEN-1:0] cap_vec;
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i < NUM_IN) begin : g_in
      assign cap_vec[i] = pin_in[i];
    end else begin : g_out
      assign cap_vec[i] = core_out[i-NUM_IN];
    end
  end

  // bypass stage
  logic byp_sr, byp_nx, byp_en;
  always_comb begin
    byp_en = (dec.path == PATH_BYP) && (cap || shf);
    byp_nx = cap ? 1'b0 : tdi;
  end
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_sr <= 1'b0;
    else if (byp_en) byp_sr <= byp_nx;
  end

  // identification register
  logic [ID_W-1:0] id_sr, id_nx;
  logic            id_en;
  always_comb begin
    id_en = (dec.path == PATH_ID) && (cap || shf);
    id_nx = cap ? {ID_CODE[ID_W-1:1], 1'b1} : {tdi, id_sr[ID_W-1:1]};
  end
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_sr <= '0;
    else if (id_en) id_sr <= id_nx;
  end

  // boundary chain shift stage
  logic [BSR_LEN-1:0] bsr_sr, bsr_nx;
  logic               bsr_en;
  always_comb begin
    bsr_en = (dec.path == PATH_BSR) && (cap || shf);
    if (cap) bsr_nx = cap_vec;
    else     bsr_nx = {tdi, bsr_sr[BSR_LEN-1:1]};
  end
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_sr <= '0;
    else if (bsr_en) bsr_sr <= bsr_nx;
  end

  // boundary update latches, falling edge
  logic [BSR_LEN-1:0] bsr_upd;
  logic               upd_en;
  assign upd_en = (state == ST_UPD_DR) && dec.bsr_upd;
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      bsr_upd <= '0;
    else if (upd_en) bsr_upd <= bsr_sr;
  end

  always_comb begin
    case (dec.path)
      PATH_ID:  dr_lsb = id_sr[0];
      PATH_BSR: dr_lsb = bsr_sr[0];
      default:  dr_lsb = byp_sr;
    endcase
  end

  assign pin_out = dec.drive ? bsr_upd[NUM_IN +: NUM_OUT] : core_out;

  assert_bypass_zero_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && dec.path == PATH_BYP) |=> (byp_sr == 1'b0));

  assert_id_lsb_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && dec.path == PATH_ID) |=> id_sr[0]);

  assert_upd_hold_R9: assert property (@(posedge tck) disable iff (!rst_n)
    !(state == ST_UPD_DR && dec.bsr_upd) |-> $stable(bsr_upd));

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import tap_pkg::*;
#(
  parameter int          NUM_IN  = 8,
  parameter int          NUM_OUT = 8,
  parameter logic [31:0] ID_CODE = 32'h1000_0FFF
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [NUM_IN-1:0]  pin_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [NUM_OUT-1:0] pin_out,
  output logic               pad_hiz,
  output logic               bsr_drive
);

  localparam int SYNC_W = 2;

  // asynchronous assert, synchronous release
  logic [SYNC_W-1:0] rst_sync;
  logic              rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[SYNC_W-2:0], 1'b1};
  end
  assign rst_n = rst_sync[SYNC_W-1];

  tap_state_e state;
  ir_dec_t    dec;
  logic       ir_lsb, dr_lsb;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .dec    (dec)
  );

  tap_dr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ID_CODE(ID_CODE)) u_dr (
    .tck      (tck),
    .rst_n    (rst_n),
    .state    (state),
    .tdi      (tdi),
    .dec      (dec),
    .pin_in   (pin_in),
    .core_out (core_out),
    .dr_lsb   (dr_lsb),
    .pin_out  (pin_out)
  );

  // serial output, falling edge
  logic tdo_nx, oe_nx, tdo_en;
  always_comb begin
    oe_nx  = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_en = oe_nx;
    tdo_nx = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
  end
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= oe_nx;
      if (tdo_en) tdo <= tdo_nx;
    end
  end

  assign pad_hiz   = dec.hiz;
  assign bsr_drive = dec.drive;

  assert_oe_shift_only_R12: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_hiz_bypass_R11: assert property (@(posedge tck) disable iff (!rst_n)
    pad_hiz |-> (!bsr_drive && pin_out == core_out));

endmodule

// File: tb/tb_jtag_tap.sv
`timescale 1ns/1ps
module tb_jtag_tap;

  localparam int          NI   = 3;
  localparam int          NO   = 4;
  localparam int          BL   = NI + NO;
  localparam logic [31:0] IDV  = 32'h5A5A_1234;
  localparam logic [31:0] IDX  = 32'h5A5A_1235;
  localparam logic [NI-1:0] PIN  = 3'b101;
  localparam logic [NO-1:0] CORE = 4'b0110;
  localparam logic [BL-1:0] BCAP = {CORE, PIN};
  localparam int          SLEN = 40;
  localparam logic [63:0] SPAT = 64'h0000_00C3_A596_F01E;

  // vector: opcode, path (0 bypass,1 id,2 chain), hiz, drive
  localparam int NV = 9;
  localparam logic [11:0] VEC [NV] = '{
    {8'hFF, 2'd0, 1'b0, 1'b0},
    {8'h00, 2'd2, 1'b0, 1'b1},
    {8'h01, 2'd2, 1'b0, 1'b0},
    {8'h02, 2'd1, 1'b0, 1'b0},
    {8'h04, 2'd0, 1'b0, 1'b1},
    {8'h08, 2'd0, 1'b1, 1'b0},
    {8'h55, 2'd0, 1'b0, 1'b0},
    {8'h80, 2'd0, 1'b0, 1'b0},
    {8'h03, 2'd0, 1'b0, 1'b0}
  };

  logic tck, trst_n, tms, tdi;
  logic [NI-1:0] pin_in;
  logic [NO-1:0] core_out, pin_out;
  logic tdo, tdo_oe, pad_hiz, bsr_drive;
  logic pos_tdo;

  int tests, fails, cycles;

  jtag_tap #(.NUM_IN(NI), .NUM_OUT(NO), .ID_CODE(IDV)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .pin_in(pin_in), .core_out(core_out),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
    .pad_hiz(pad_hiz), .bsr_drive(bsr_drive)
  );

  initial tck = 1'b0;
  always #2.5 tck = ~tck;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge tck);
      cycles++;
      if (cycles > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog expired: actual=%0d cycles expected<100000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1 pos_tdo = tdo;
    @(negedge tck); #1;
  endtask

  task automatic do_reset();
    @(negedge tck); #1;
    trst_n = 1'b0; tms = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    trst_n = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  // from Run-Test/Idle to Exit1-IR
  task automatic ir_shift(input logic [7:0] op, output logic [7:0] cap);
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    cap[0] = tdo;
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, op[i]);
      if (i < 7) cap[i+1] = tdo;
    end
  endtask

  task automatic ir_finish();
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [7:0] op);
    logic [7:0] c;
    ir_shift(op, c);
    ir_finish();
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout,
                         output logic ok_edge, output logic ok_oe);
    logic prev;
    dout = '0; ok_edge = 1'b1; ok_oe = 1'b1;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    dout[0] = tdo;
    if (tdo_oe !== 1'b1) ok_oe = 1'b0;
    for (int i = 0; i < n; i++) begin
      prev = tdo;
      tick(i == n - 1, din[i]);
      if (pos_tdo !== prev) ok_edge = 1'b0;
      if (i < n - 1) begin
        dout[i+1] = tdo;
        if (tdo_oe !== 1'b1) ok_oe = 1'b0;
      end
    end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  function automatic logic [63:0] exp_stream(input int path, input int n, input logic [63:0] din);
    logic [63:0] e;
    int len;
    logic [63:0] capv;
    e = '0;
    case (path)
      1: begin len = 32; capv = {32'h0, IDX}; end
      2: begin len = BL; capv = {{(64-BL){1'b0}}, BCAP}; end
      default: begin len = 1; capv = '0; end
    endcase
    for (int j = 0; j < n; j++) e[j] = (j < len) ? capv[j] : din[j-len];
    return e;
  endfunction

  initial begin
    logic [63:0] got;
    logic        ok_e, ok_o;
    logic [7:0]  c8;
    logic [BL-1:0] pre;
    tests = 0; fails = 0;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pin_in = PIN; core_out = CORE;
    do_reset();

    // reset state (R2, R10, R11, R12)
    check("R12 tdo_oe after reset", {63'h0, tdo_oe}, 64'h0);
    check("R11 pad_hiz after reset", {63'h0, pad_hiz}, 64'h0);
    check("R10 pin_out follows core after reset", {60'h0, pin_out}, {60'h0, CORE});
    dr_scan(32, 64'h0, got, ok_e, ok_o);
    check("R2 R7 default path is identity", got, {32'h0, IDX});
    check("R12 tdo_oe in Shift-DR", {63'h0, ok_o}, 64'h1);
    check("R12 tdo stable at rising edge", {63'h0, ok_e}, 64'h1);
    check("R12 tdo_oe off in idle", {63'h0, tdo_oe}, 64'h0);

    // capture value of the instruction stage (R3)
    ir_shift(8'hFF, c8);
    ir_finish();
    check("R3 Capture-IR pattern", {56'h0, c8}, 64'h01);

    // opcode table walk (R5, R6, R7, R8, R10, R11)
    for (int v = 0; v < NV; v++) begin
      load_ir(VEC[v][11:4]);
      check($sformatf("R5 R11 pad_hiz op=%h", VEC[v][11:4]), {63'h0, pad_hiz}, {63'h0, VEC[v][1]});
      check($sformatf("R5 R10 bsr_drive op=%h", VEC[v][11:4]), {63'h0, bsr_drive}, {63'h0, VEC[v][0]});
      dr_scan(SLEN, SPAT, got, ok_e, ok_o);
      check($sformatf("R5 R6 R7 R8 path stream op=%h", VEC[v][11:4]), got,
            exp_stream(int'(VEC[v][3:2]), SLEN, SPAT));
    end

    // instruction latch waits for Update-IR (R4)
    load_ir(8'h08);
    ir_shift(8'h00, c8);
    check("R4 pad_hiz held before Update-IR", {63'h0, pad_hiz}, 64'h1);
    check("R4 bsr_drive held before Update-IR", {63'h0, bsr_drive}, 64'h0);
    ir_finish();
    check("R4 pad_hiz after Update-IR", {63'h0, pad_hiz}, 64'h0);
    check("R4 bsr_drive after Update-IR", {63'h0, bsr_drive}, 64'h1);

    // preload, then drive, then clamp (R9, R10)
    pre = 7'b1011001;
    load_ir(8'h01);
    dr_scan(BL, {57'h0, pre}, got, ok_e, ok_o);
    check("R9 sample leaves pin_out on core", {60'h0, pin_out}, {60'h0, CORE});
    load_ir(8'h00);
    check("R10 external test drives latches", {60'h0, pin_out}, {60'h0, pre[NI +: NO]});
    load_ir(8'h04);
    dr_scan(5, 64'h1F, got, ok_e, ok_o);
    check("R9 R10 clamp keeps latches", {60'h0, pin_out}, {60'h0, pre[NI +: NO]});
    check("R10 clamp bsr_drive", {63'h0, bsr_drive}, 64'h1);
    load_ir(8'h02);
    check("R10 identity releases pads", {60'h0, pin_out}, {60'h0, CORE});

    // five tms=1 from Shift-DR (R1)
    load_ir(8'hFF);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R12 tdo_oe in Shift-DR", {63'h0, tdo_oe}, 64'h1);
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
    check("R1 tdo_oe off after tms run", {63'h0, tdo_oe}, 64'h0);
    tick(1'b0, 1'b0);
    dr_scan(32, 64'h0, got, ok_e, ok_o);
    check("R1 R2 tms reset restores identity", got, {32'h0, IDX});

    // asynchronous reset mid-operation (R2)
    load_ir(8'h08);
    do_reset();
    check("R2 trst_n clears pad_hiz", {63'h0, pad_hiz}, 64'h0);
    dr_scan(32, 64'h0, got, ok_e, ok_o);
    check("R2 trst_n restores identity", got, {32'h0, IDX});

    summary();
    $finish;
  end

endmodule